// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives a multi-channel analog-to-digital converter through a simple start/done handshake. Software writes a mode, a channel number and a start bit in one register write. The controller issues one conversion request at a time. It tags each returned result with the channel it belongs to and strobes an end-of-conversion pulse. Four modes exist: one conversion of a fixed channel, repeated conversions of a fixed channel, one downward scan, and repeated downward scans. A scan converts the programmed channel and then every lower channel down to channel 0.

Configuration written while the converter is active is held back until a boundary. For a fixed-channel conversion the boundary is the end of that conversion. For a scan it is the end of channel 0. One case is special. If a scan mode is written while a fixed conversion of channel n runs, the controller goes on with channels n-1 down to 0, and the channel just written is not used for that scan. A mode change while idle starts nothing unless the same write sets start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode readback is 00, the channel readback is 0, and start, busy and the end-of-conversion strobe are all 0.
- R2: Mode 00 (fixed single) with start written 1 converts the programmed channel once. The block then goes idle, and the start readback returns to 0.
- R3: Mode 10 (auto scan single) with start written 1 and channel n converts channels n, n-1, ..., 0 in that order. The block then goes idle, and start reads 0.
- R4: A write with start 0 while idle updates the mode and channel readback but launches no conversion. This holds for scan modes too.
- R5: If mode 10 or 11 is written while a fixed conversion of channel n runs, the next conversions are channels n-1 down to 0. The channel value in that write is ignored. For n = 0 nothing follows.
- R6: Writes made during a scan do not change the scan. It still runs down to channel 0.
- R7: In mode 01 (fixed continuous) the channel repeats while start stays 1. A new channel number takes effect after the conversion in progress.
- R8: Writing start 0 in a continuous mode stops at the next boundary. In fixed mode that is after the current conversion; in scan mode it is after channel 0.
- R9: In mode 11 (auto scan continuous), each scan that ends at channel 0 restarts from the latched channel.
- R10: Busy is 1 from the cycle the first request issues until the last conversion of the sequence completes. A conversion request is only issued while busy.
- R11: Each completed conversion produces exactly one one-clock end-of-conversion pulse, in the cycle after done. It comes with the 10-bit data and the 4-bit channel of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_mode_i | input | 2 | Mode written (00 fixed single, 01 fixed continuous, 10 scan single, 11 scan continuous) |
| cfg_chan_i | input | 4 | Channel written |
| cfg_start_i | input | 1 | Start bit written |
| cfg_mode_o | output | 2 | Mode readback |
| cfg_chan_o | output | 4 | Channel readback |
| cfg_start_o | output | 1 | Start readback |
| busy_o | output | 1 | Sequence active |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 4 | Channel of the request |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | 10 | Converter result |
| res_data_o | output | 10 | Result data |
| res_chan_o | output | 4 | Result channel tag |
| eoc_o | output | 1 | End-of-conversion strobe |

## Verification
The hardest case to reach is the fixed-to-scan carryover. The mode write has to land inside the window of a fixed conversion, after the request and before done. The bench counts the request and converter-model latency so that its write always lands in that window. It then sweeps every channel 0 to 15, which covers the case where nothing follows. Stopping the continuous modes is driven the same way. The stop write is placed just after a result strobe, so the controller is known to be inside a conversion and the number of remaining results is exact.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_FIX_ONE  = 2'b00,
    MODE_FIX_RPT  = 2'b01,
    MODE_SCAN_ONE = 2'b10,
    MODE_SCAN_RPT = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  function automatic logic mode_is_scan(seq_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_rpt(seq_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      mode_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            start_i,
  input  logic            hw_clr_i,
  output seq_mode_e       mode_o,
  output logic [CH_W-1:0] chan_o,
  output logic            start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_FIX_ONE;
      chan_o  <= '0;
      start_o <= 1'b0;
    end else if (we_i) begin
      mode_o  <= seq_mode_e'(mode_i);
      chan_o  <= chan_i;
      start_o <= start_i;
    end else if (hw_clr_i) begin
      start_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_mode_e       reg_mode_i,
  input  logic [CH_W-1:0] reg_chan_i,
  input  logic            reg_start_i,
  input  logic            conv_done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_chan_o,
  output logic            busy_o,
  output logic            clr_start_o,
  output logic            cap_o,
  output logic [CH_W-1:0] cap_chan_o
);
  seq_state_e      st_q, st_d;
  seq_mode_e       act_q, act_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            last_ch;

  assign last_ch = (cur_q == '0);

  always_comb begin
    st_d        = st_q;
    act_d       = act_q;
    cur_d       = cur_q;
    clr_start_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (reg_start_i) begin
        st_d  = ST_REQ;
        act_d = reg_mode_i;
        cur_d = reg_chan_i;
      end
      ST_REQ: st_d = ST_WAIT;
      ST_WAIT: if (conv_done_i) begin
        if (mode_is_scan(act_q) && !last_ch) begin
          st_d  = ST_REQ;                       // scan still descending
          cur_d = cur_q - 1'b1;
        end else if (!reg_start_i) begin
          st_d  = ST_IDLE;
        end else if (!mode_is_scan(act_q) && mode_is_scan(reg_mode_i) && !last_ch) begin
          st_d  = ST_REQ;                       // fixed -> scan carries on below n
          act_d = reg_mode_i;
          cur_d = cur_q - 1'b1;
        end else if (!mode_is_rpt(act_q)) begin
          st_d        = ST_IDLE;
          clr_start_o = 1'b1;
        end else begin
          st_d  = ST_REQ;                       // continuous restart from latched channel
          act_d = reg_mode_i;
          cur_d = reg_chan_i;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      act_q <= MODE_FIX_ONE;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  assign conv_start_o = (st_q == ST_REQ);
  assign conv_chan_o  = cur_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign cap_o        = (st_q == ST_WAIT) && conv_done_i;
  assign cap_chan_o   = cur_q;
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int CH_W   = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              eoc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      chan_o <= '0;
      eoc_o  <= 1'b0;
    end else begin
      eoc_o <= cap_i;
      if (cap_i) begin
        data_o <= data_i;
        chan_o <= chan_i;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CH_W-1:0]   cfg_chan_i,
  input  logic              cfg_start_i,
  output logic [1:0]        cfg_mode_o,
  output logic [CH_W-1:0]   cfg_chan_o,
  output logic              cfg_start_o,
  output logic              busy_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic              eoc_o
);
  seq_mode_e       reg_mode;
  logic [CH_W-1:0] reg_chan;
  logic            reg_start;
  logic            clr_start;
  logic            cap;
  logic [CH_W-1:0] cap_chan;

  adc_seq_regs #(.CH_W(CH_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .mode_i   (cfg_mode_i),
    .chan_i   (cfg_chan_i),
    .start_i  (cfg_start_i),
    .hw_clr_i (clr_start),
    .mode_o   (reg_mode),
    .chan_o   (reg_chan),
    .start_o  (reg_start)
  );

  adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_mode_i   (reg_mode),
    .reg_chan_i   (reg_chan),
    .reg_start_i  (reg_start),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .busy_o       (busy_o),
    .clr_start_o  (clr_start),
    .cap_o        (cap),
    .cap_chan_o   (cap_chan)
  );

  adc_seq_result #(.CH_W(CH_W), .DATA_W(DATA_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .chan_i (cap_chan),
    .data_i (conv_data_i),
    .data_o (res_data_o),
    .chan_o (res_chan_o),
    .eoc_o  (eoc_o)
  );

  assign cfg_mode_o  = reg_mode;
  assign cfg_chan_o  = reg_chan;
  assign cfg_start_o = reg_start;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_start_o,
  input logic            busy_o,
  input logic            conv_start_o,
  input logic [CH_W-1:0] conv_chan_o,
  input logic            conv_done_i,
  input logic            eoc_o
);
  // R11
  eoc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  // R11
  eoc_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && busy_o && !conv_start_o) |=> eoc_o);

  // R10
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o);

  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(conv_done_i));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_start_o) |=> !conv_start_o);

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_start_o  (cfg_start_o),
  .busy_o       (busy_o),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .conv_done_i  (conv_done_i),
  .eoc_o        (eoc_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [3:0] cfg_chan = 4'd0;
  logic       cfg_start = 1'b0;
  logic [1:0] mode_rb;
  logic [3:0] chan_rb;
  logic       start_rb, busy, conv_start, eoc;
  logic [3:0] conv_chan, res_chan;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic [9:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  int log_q [0:511];
  int ln = 0;
  int eidx = 0;
  int kconv = 0;
  logic pend = 1'b0;
  int   cnt = 0;
  logic [3:0] mch = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_chan_i(cfg_chan), .cfg_start_i(cfg_start),
    .cfg_mode_o(mode_rb), .cfg_chan_o(chan_rb), .cfg_start_o(start_rb),
    .busy_o(busy), .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .res_data_o(res_data), .res_chan_o(res_chan), .eoc_o(eoc)
  );

  function automatic logic [9:0] fdat(int ch, int k);
    return 10'((ch * 41 + k * 3) & 1023);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      pend <= 1'b1;
      cnt  <= LAT;
      mch  <= conv_chan;
    end else if (pend) begin
      if (cnt == 0) begin
        conv_done <= 1'b1;
        conv_data <= fdat(int'(mch), kconv);
        kconv     <= kconv + 1;
        pend      <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  // result monitor, R11
  always @(negedge clk) begin
    if (rst_n && eoc) begin
      chk(res_data == fdat(int'(res_chan), eidx), "R11 data", int'(res_data), int'(fdat(int'(res_chan), eidx)));
      log_q[ln] = int'(res_chan);
      ln   = ln + 1;
      eidx = eidx + 1;
    end
  end

  task automatic wr(input logic [1:0] m, input int ch, input logic s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_chan = 4'(ch); cfg_start = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (3) @(negedge clk);
    while (busy && g < 3000) begin @(negedge clk); g++; end
    #1;
  endtask

  task automatic wait_cnt(input int target);
    int g = 0;
    do begin @(negedge clk); #1; g++; end while (ln < target && g < 3000);
  endtask

  task automatic chk_desc(input int base, input int n, input string req);
    bit ok = (ln - base == n + 1);
    for (int i = 0; i <= n && ok; i++) if (log_q[base+i] != n - i) ok = 0;
    chk(ok, req, ln - base, n + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, w, s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mode_rb == 2'b00 && chan_rb == 4'd0, "R1 cfg", int'({mode_rb, chan_rb}), 0);
    chk(!start_rb && !busy && !eoc, "R1 flags", int'({start_rb, busy, eoc}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 fixed single sweep
    for (int n = 0; n < 16; n++) begin
      base = ln;
      wr(2'b00, n, 1'b1);
      repeat (2) @(negedge clk);
      chk(busy, "R10 busy during", 0, 1);
      wait_idle();
      chk(ln - base == 1 && log_q[base] == n, "R2 fixed single", log_q[base], n);
      chk(!start_rb, "R2 start clear", int'(start_rb), 0);
    end

    // R3 scan single sweep
    for (int n = 0; n < 16; n++) begin
      base = ln;
      wr(2'b10, n, 1'b1);
      wait_idle();
      chk_desc(base, n, "R3 scan single");
      chk(!start_rb && !busy, "R3 idle after", int'({start_rb, busy}), 0);
    end

    // R4 idle mode writes without start
    base = ln;
    wr(2'b10, 7, 1'b0);
    wr(2'b11, 9, 1'b0);
    repeat (40) @(negedge clk);
    chk(ln == base && !busy, "R4 no launch", ln - base, 0);
    chk(mode_rb == 2'b11 && chan_rb == 4'd9, "R4 readback", int'({mode_rb, chan_rb}), 57);

    // R5 fixed -> scan carryover sweep
    for (int n = 0; n < 16; n++) begin
      base = ln;
      wr(2'b00, n, 1'b1);
      repeat (2) @(negedge clk);
      wr(2'b10, 12, 1'b1);
      wait_idle();
      chk_desc(base, n, "R5 carryover");
    end

    // R6 channel write during scan ignored
    base = ln;
    wr(2'b10, 5, 1'b1);
    repeat (2) @(negedge clk);
    wr(2'b10, 12, 1'b1);
    wait_idle();
    chk_desc(base, 5, "R6 scan unchanged");
    chk(!start_rb, "R6 start clear", int'(start_rb), 0);

    // R7 fixed continuous, new channel at boundary; R8 stop
    base = ln;
    wr(2'b01, 3, 1'b1);
    wait_cnt(base + 2);
    chk(log_q[base] == 3 && log_q[base+1] == 3, "R7 repeat", log_q[base+1], 3);
    w = ln;
    wr(2'b01, 7, 1'b1);
    wait_cnt(w + 4);
    chk(log_q[w] == 3, "R7 current kept", log_q[w], 3);
    chk(log_q[w+1] == 7 && log_q[w+2] == 7 && log_q[w+3] == 7, "R7 new chan", log_q[w+1], 7);
    s = ln;
    wr(2'b01, 7, 1'b0);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(ln == s + 1 && !busy, "R8 fixed stop", ln - s, 1);

    // R9 scan continuous restart; R8 stop at channel 0
    base = ln;
    wr(2'b11, 2, 1'b1);
    wait_cnt(base + 4);
    wr(2'b11, 2, 1'b0);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(ln == base + 6, "R8 scan stop", ln - base, 6);
    begin
      bit ok = 1;
      for (int i = 0; i < 6; i++) if (log_q[base+i] != 2 - (i % 3)) ok = 0;
      chk(ok, "R9 restart", log_q[base+3], 2);
    end

    // R11 one strobe per conversion
    chk(eidx == kconv, "R11 count", eidx, kconv);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule